// File: doc/BRIEF.md
# Serial Control and Status Port for a Tone Signalling Block

This block is the host-facing control port of a dual-tone signalling engine. A host drives four slow pins: a serial clock, an enable strobe, a direction select and a single data line. When the direction select is low, the port accepts a 14-bit control word one bit per serial clock edge. While the strobe is high, it copies that word into the live control register. When the direction select is high, the port returns the 4-bit code of the most recently detected digit, one bit at a time, on the same data line.

All four pins are asynchronous to the block. They pass through a synchronizer on the fast system clock, and the serial clock and strobe are then edge-detected there. The live register is split into named fields for neighbouring blocks: operating mode, transmit mute, detection guard-time select, level code and tone code. The port also derives the receive/transmit enables and the receive gain setting from those fields.

The read side is a three-state machine:
- `RD_OFF`: the direction select is low and the data line is released.
- `RD_ARMED`: the direction select is high, no digit has been captured yet, and the line drives 0.
- `RD_SHIFT`: a digit is held and rotated out.

The transitions are:
- `OFF->ARMED`: the direction select rises.
- `ARMED->SHIFT`: a strobe rises.
- `SHIFT->SHIFT`: a serial clock advances the bit, or a new strobe reloads the digit.
- `any->OFF`: the direction select falls.

Top module: `tone_ctl_serial_if`

## Requirements
- R1: While the direction select is low, each synchronized rising serial-clock edge shifts the data pin into the top of a 14-bit shadow register, moving its contents one place toward bit 0. The first bit of a frame therefore lands in bit 0 after 14 edges. The frame order is tone bits 0..3, level bits 0..3, guard bits 0..1, mute, mode bits 0..2.
- R2: While the strobe is high and the direction select is low, the live register is loaded from the shadow register every system cycle. Otherwise the live register holds its value.
- R3: The live register maps to fields by bit position: [3:0] tone, [7:4] level code, [9:8] guard select, [10] mute, [13:11] mode. Each field is presented on its own output.
- R4: The mode codes are 0 receive, 1 dual-tone transmit, 2 single tone, 3 power-down with oscillator, 4 full power-down and 5 loopback. Receive enable is high for modes 0 and 5. Transmit enable is high for modes 1, 2 and 5, and only when mute is 0. Codes 6 and 7 enable neither.
- R5: With the direction select high, a rising strobe captures the 4-bit digit input. Bit 0 of that digit appears on the data output, with output enable high, as soon as the strobe edge is seen.
- R6: Each later rising serial-clock edge while reading presents the next bit (1, 2, 3). After bit 3 the sequence wraps to bit 0 and repeats until another strobe reloads it. A change on the digit input has no effect without a strobe.
- R7: The data output enable is high only while the direction select is high. Lowering the direction select discards the captured digit. A later read that sees no strobe drives 0 on the data output.
- R8: The receive gain setting is derived from the level code. Codes 0..10 select fixed gain (select 0) with gain in half-dB of -10 + 5 × code. Code 11 selects clamp (select 1). Code 12 selects automatic (select 2). Codes 13..15 are unused (select 3). The half-dB output is 0 for codes 11..15.
- R9: After reset the live register is all zeros, so the mode is receive and every field is 0. The data output enable is low.
- R10: A frame shorter than 14 clock edges is still transferred by the strobe. The shadow register keeps the older bits that were shifted down and were not replaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Host serial clock |
| ser_en_i | input | 1 | Host transfer/load strobe |
| ser_rw_i | input | 1 | Direction select, 1 = read |
| ser_data_i | input | 1 | Data pin, input side |
| digit_i | input | 4 | Code of the detected digit |
| ser_data_o | output | 1 | Data pin, output side |
| ser_data_oe_o | output | 1 | Data pin output enable |
| mode_o | output | 3 | Operating mode field |
| squelch_o | output | 1 | Transmit mute field |
| guard_o | output | 2 | Guard-time select field |
| gain_code_o | output | 4 | Level/gain code field |
| tone_o | output | 4 | Tone code field |
| tx_en_o | output | 1 | Tone generator enable |
| rx_en_o | output | 1 | Receiver enable |
| agc_sel_o | output | 2 | Gain select: 0 fixed, 1 clamp, 2 auto, 3 unused |
| agc_gain_hdb_o | output | 7 | Fixed receive gain in half-dB, signed |

## Verification
The hardest state to reach from the pins is the wrap of the read rotation. It takes a strobe followed by four serial clocks with the direction select held high, and with the digit input changed meanwhile to show that the reload needs a strobe. The stimulus clocks past bit 3 twice and then swaps the digit without a strobe. The short-frame case is reached by first writing a complete word and then sending only three bits before the strobe, so the expected word mixes old and new bits.

// File: rtl/tone_ctl_pkg.sv
package tone_ctl_pkg;
    localparam int CTRL_W  = 14;
    localparam int DIGIT_W = 4;

    typedef enum logic [2:0] {
        MODE_RX     = 3'd0,
        MODE_TX     = 3'd1,
        MODE_SINGLE = 3'd2,
        MODE_PD_OSC = 3'd3,
        MODE_PD_ALL = 3'd4,
        MODE_LOOP   = 3'd5
    } op_mode_e;

    typedef enum logic [1:0] {
        AGC_FIXED  = 2'd0,
        AGC_CLAMP  = 2'd1,
        AGC_AUTO   = 2'd2,
        AGC_UNUSED = 2'd3
    } agc_sel_e;

    typedef enum logic [1:0] {
        RD_OFF   = 2'd0,
        RD_ARMED = 2'd1,
        RD_SHIFT = 2'd2
    } rd_state_e;

    typedef struct packed {
        logic [2:0] mode;
        logic       mute;
        logic [1:0] guard;
        logic [3:0] level;
        logic [3:0] tone;
    } ctrl_word_t;
endpackage

// File: rtl/ser_pin_sync.sv
module ser_pin_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);
    logic [WIDTH-1:0] stage_q [STAGES+1];

    genvar g;
    generate
        for (g = 0; g <= STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= '0;
                end else if (g == 0) begin
                    stage_q[g] <= pins_i;
                end else begin
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
    assign prev_o = stage_q[STAGES];
endmodule

// File: rtl/ser_rd_fsm.sv
module ser_rd_fsm
    import tone_ctl_pkg::*;
#(
    parameter int DW = DIGIT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rw_s,
    input  logic          en_rise,
    input  logic          sclk_rise,
    input  logic [DW-1:0] digit_i,
    output logic          data_o,
    output logic          oe_o
);
    localparam int IDX_W = (DW > 1) ? $clog2(DW) : 1;

    rd_state_e        state_q, state_d;
    logic [DW-1:0]    rd_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_nx;

    assign idx_nx = (idx_q == IDX_W'(DW-1)) ? '0 : idx_q + 1'b1;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_OFF:   if (rw_s) state_d = RD_ARMED;
            RD_ARMED: if (!rw_s) state_d = RD_OFF;
                      else if (en_rise) state_d = RD_SHIFT;
            RD_SHIFT: if (!rw_s) state_d = RD_OFF;
            default:  state_d = RD_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_OFF;
            rd_q    <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (!rw_s) begin
                rd_q  <= '0;
                idx_q <= '0;
            end else if (en_rise && state_q != RD_OFF) begin
                rd_q  <= digit_i;
                idx_q <= '0;
            end else if (sclk_rise && state_q == RD_SHIFT) begin
                idx_q <= idx_nx;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            RD_OFF:   begin oe_o = 1'b0; data_o = 1'b0; end
            RD_ARMED: begin oe_o = 1'b1; data_o = 1'b0; end
            RD_SHIFT: begin oe_o = 1'b1; data_o = rd_q[idx_q]; end
            default:  begin oe_o = 1'b0; data_o = 1'b0; end
        endcase
    end

    assert_load_bit0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rw_s && en_rise && state_q != RD_OFF) |=> (oe_o && data_o == $past(digit_i[0])));

    assert_wrap_to_bit0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rw_s && state_q == RD_SHIFT && sclk_rise && !en_rise && idx_q == IDX_W'(DW-1))
        |=> (data_o == $past(rd_q[0])));

    assert_release_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rw_s) |=> !oe_o);
endmodule

// File: rtl/ctrl_field_dec.sv
module ctrl_field_dec
    import tone_ctl_pkg::*;
(
    input  ctrl_word_t        word_i,
    output logic              tx_en_o,
    output logic              rx_en_o,
    output logic [1:0]        agc_sel_o,
    output logic signed [6:0] agc_gain_hdb_o
);
    always_comb begin
        rx_en_o = 1'b0;
        tx_en_o = 1'b0;
        unique case (word_i.mode)
            MODE_RX:     rx_en_o = 1'b1;
            MODE_TX,
            MODE_SINGLE: tx_en_o = !word_i.mute;
            MODE_LOOP:   begin rx_en_o = 1'b1; tx_en_o = !word_i.mute; end
            default:     ;
        endcase
    end

    always_comb begin
        agc_gain_hdb_o = '0;
        if (word_i.level <= 4'd10) begin
            agc_sel_o      = AGC_FIXED;
            agc_gain_hdb_o = 7'(signed'({3'b000, word_i.level}) * 5) - 7'sd10;
        end else if (word_i.level == 4'd11) begin
            agc_sel_o = AGC_CLAMP;
        end else if (word_i.level == 4'd12) begin
            agc_sel_o = AGC_AUTO;
        end else begin
            agc_sel_o = AGC_UNUSED;
        end
    end
endmodule

// File: rtl/tone_ctl_serial_if.sv
module tone_ctl_serial_if
    import tone_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_clk_i,
    input  logic               ser_en_i,
    input  logic               ser_rw_i,
    input  logic               ser_data_i,
    input  logic [3:0]         digit_i,
    output logic               ser_data_o,
    output logic               ser_data_oe_o,
    output logic [2:0]         mode_o,
    output logic               squelch_o,
    output logic [1:0]         guard_o,
    output logic [3:0]         gain_code_o,
    output logic [3:0]         tone_o,
    output logic               tx_en_o,
    output logic               rx_en_o,
    output logic [1:0]         agc_sel_o,
    output logic signed [6:0]  agc_gain_hdb_o
);
    localparam int PIN_N = 4;

    logic [PIN_N-1:0] sync_s, prev_s;
    logic sclk_s, en_s, rw_s, data_s;
    logic sclk_rise, en_rise;

    ser_pin_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i ({ser_data_i, ser_rw_i, ser_en_i, ser_clk_i}),
        .sync_o (sync_s),
        .prev_o (prev_s)
    );

    assign sclk_s    = sync_s[0];
    assign en_s      = sync_s[1];
    assign rw_s      = sync_s[2];
    assign data_s    = sync_s[3];
    assign sclk_rise = sclk_s & ~prev_s[0];
    assign en_rise   = en_s & ~prev_s[1];

    logic [CTRL_W-1:0] shadow_q;
    ctrl_word_t        live_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
            live_q   <= '0;
        end else begin
            if (sclk_rise && !rw_s) begin
                shadow_q <= {data_s, shadow_q[CTRL_W-1:1]};
            end
            if (en_s && !rw_s) begin
                live_q <= ctrl_word_t'(shadow_q);
            end
        end
    end

    assert_shift_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && !rw_s) |=> (shadow_q[CTRL_W-1] == $past(data_s)));

    assert_transfer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_s && !rw_s) |=> (live_q == $past(shadow_q)));

    assert_hold_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_s && !rw_s) |=> $stable(live_q));

    ser_rd_fsm #(.DW(DIGIT_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rw_s      (rw_s),
        .en_rise   (en_rise),
        .sclk_rise (sclk_rise),
        .digit_i   (digit_i),
        .data_o    (ser_data_o),
        .oe_o      (ser_data_oe_o)
    );

    ctrl_field_dec u_dec (
        .word_i         (live_q),
        .tx_en_o        (tx_en_o),
        .rx_en_o        (rx_en_o),
        .agc_sel_o      (agc_sel_o),
        .agc_gain_hdb_o (agc_gain_hdb_o)
    );

    assign mode_o      = live_q.mode;
    assign squelch_o   = live_q.mute;
    assign guard_o     = live_q.guard;
    assign gain_code_o = live_q.level;
    assign tone_o      = live_q.tone;

    assert_mode_enables_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q.mode == MODE_PD_ALL || live_q.mode == MODE_PD_OSC) |-> !(tx_en_o || rx_en_o));
endmodule

// File: tb/tone_ctl_serial_if_tb_top.sv
module tone_ctl_serial_if_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_en = 1'b0, ser_rw = 1'b0, ser_din = 1'b0;
    logic [3:0] digit = 4'd0;
    logic ser_dout, ser_oe, squelch, tx_en, rx_en;
    logic [2:0] mode;
    logic [1:0] guard, agc_sel;
    logic [3:0] gain_code, tone;
    logic signed [6:0] hdb;

    always #10 clk = ~clk;

    tone_ctl_serial_if dut_i (
        .clk(clk), .rst_n(rst_n),
        .ser_clk_i(ser_clk), .ser_en_i(ser_en), .ser_rw_i(ser_rw), .ser_data_i(ser_din),
        .digit_i(digit),
        .ser_data_o(ser_dout), .ser_data_oe_o(ser_oe),
        .mode_o(mode), .squelch_o(squelch), .guard_o(guard), .gain_code_o(gain_code),
        .tone_o(tone), .tx_en_o(tx_en), .rx_en_o(rx_en),
        .agc_sel_o(agc_sel), .agc_gain_hdb_o(hdb)
    );

    typedef enum int {S_MODE, S_SQ, S_GUARD, S_GAIN, S_TONE, S_TX, S_RX,
                      S_AGC, S_HDB, S_DATA, S_OE} sel_e;
    typedef struct { string req; sel_e sel; int exp; } item_t;

    item_t sb_q[$];
    event  check_ev;
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;

    function automatic int observe(sel_e s);
        case (s)
            S_MODE:  return int'(mode);
            S_SQ:    return int'(squelch);
            S_GUARD: return int'(guard);
            S_GAIN:  return int'(gain_code);
            S_TONE:  return int'(tone);
            S_TX:    return int'(tx_en);
            S_RX:    return int'(rx_en);
            S_AGC:   return int'(agc_sel);
            S_HDB:   return int'(hdb);
            S_DATA:  return int'(ser_dout);
            default: return int'(ser_oe);
        endcase
    endfunction

    // monitor: pops expected items and compares with outputs
    initial begin
        forever begin
            @(check_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                int act;
                it  = sb_q.pop_front();
                act = observe(it.sel);
                n_checks++;
                if (act != it.exp) begin
                    n_fail++;
                    $display("FAIL %s sel=%s actual=%0d expected=%0d",
                             it.req, it.sel.name(), act, it.exp);
                end
            end
        end
    end

    task automatic expect_val(string req, sel_e s, int e);
        item_t it;
        it.req = req; it.sel = s; it.exp = e;
        sb_q.push_back(it);
    endtask

    task automatic flush_checks();
        ->check_ev;
        @(negedge clk);
    endtask

    task automatic ticks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(logic b);
        ser_din = b;
        ticks(4);
        ser_clk = 1'b1;
        ticks(4);
        ser_clk = 1'b0;
        ticks(2);
    endtask

    task automatic shift_bits(logic [13:0] w, int nbits);
        ser_rw = 1'b0;
        ticks(4);
        for (int i = 0; i < nbits; i++) send_bit(w[i]);
    endtask

    task automatic strobe();
        ser_en = 1'b1;
        ticks(6);
        ser_en = 1'b0;
        ticks(6);
    endtask

    function automatic logic [13:0] mkword(int m, int sq, int g, int a, int t);
        return {3'(m), 1'(sq), 2'(g), 4'(a), 4'(t)};
    endfunction

    function automatic int exp_tx(int m, int sq);
        return ((m == 1 || m == 2 || m == 5) && sq == 0) ? 1 : 0;
    endfunction

    function automatic int exp_rx(int m);
        return (m == 0 || m == 5) ? 1 : 0;
    endfunction

    task automatic expect_fields(string req, logic [13:0] w);
        int m, sq;
        m  = int'(w[13:11]);
        sq = int'(w[10]);
        expect_val(req, S_MODE,  m);
        expect_val(req, S_SQ,    sq);
        expect_val(req, S_GUARD, int'(w[9:8]));
        expect_val(req, S_GAIN,  int'(w[7:4]));
        expect_val(req, S_TONE,  int'(w[3:0]));
        expect_val("R4", S_TX, exp_tx(m, sq));
        expect_val("R4", S_RX, exp_rx(m));
    endtask

    task automatic read_start();
        ser_rw = 1'b1;
        ticks(4);
        ser_en = 1'b1;
        ticks(5);
        ser_en = 1'b0;
        ticks(4);
    endtask

    task automatic read_clk();
        ser_clk = 1'b1;
        ticks(5);
        ser_clk = 1'b0;
        ticks(4);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : driver
        logic [13:0] w, w2, shadow_exp;
        logic [3:0]  dg;
        ticks(3);
        rst_n = 1'b1;
        ticks(2);

        // R9: reset state
        expect_fields("R9", 14'd0);
        expect_val("R9", S_OE, 0);
        flush_checks();

        // R1/R3/R4: transmit mode word
        w = mkword(1, 0, 2, 5, 7);
        shift_bits(w, 14);
        strobe();
        expect_fields("R1", w);
        flush_checks();

        // R2: shift a new word without strobe, live must hold
        w2 = mkword(2, 1, 3, 9, 4'hB);
        shift_bits(w2, 14);
        ticks(4);
        expect_fields("R2", w);
        flush_checks();
        strobe();
        expect_fields("R3", w2);   // single tone, muted -> tx off
        flush_checks();

        // R4: loopback and power-down and reserved codes
        w = mkword(5, 0, 1, 12, 3);
        shift_bits(w, 14); strobe();
        expect_fields("R4", w); flush_checks();
        w = mkword(4, 0, 0, 0, 1);
        shift_bits(w, 14); strobe();
        expect_fields("R4", w); flush_checks();
        w = mkword(7, 0, 0, 0, 1);
        shift_bits(w, 14); strobe();
        expect_fields("R4", w); flush_checks();

        // R8: every level code in receive mode
        for (int c = 0; c < 16; c++) begin
            w = mkword(0, 0, 0, c, 0);
            shift_bits(w, 14); strobe();
            expect_val("R8", S_AGC, (c <= 10) ? 0 : (c == 11) ? 1 : (c == 12) ? 2 : 3);
            expect_val("R8", S_HDB, (c <= 10) ? (5 * c - 10) : 0);
            flush_checks();
        end

        // R10: short frame keeps older bits moved down
        w = mkword(3, 1, 2, 6, 9);
        shift_bits(w, 14); strobe();
        shadow_exp = w;
        w2 = 14'b00000000000101;
        shift_bits(w2, 3);
        for (int i = 0; i < 3; i++) shadow_exp = {w2[i], shadow_exp[13:1]};
        strobe();
        expect_fields("R10", shadow_exp);
        flush_checks();

        // R5/R6: read rotation with wrap
        dg = 4'b0110;
        digit = dg;
        read_start();
        expect_val("R5", S_OE, 1);
        expect_val("R5", S_DATA, int'(dg[0]));
        flush_checks();
        for (int k = 1; k < 10; k++) begin
            read_clk();
            expect_val("R6", S_DATA, int'(dg[k % 4]));
            flush_checks();
        end
        // R6: digit change without strobe ignored (now at bit 1)
        digit = 4'b1001;
        read_clk();
        expect_val("R6", S_DATA, int'(dg[2]));
        flush_checks();
        // R5: new strobe reloads
        ser_en = 1'b1; ticks(5); ser_en = 1'b0; ticks(4);
        expect_val("R5", S_DATA, 1);
        flush_checks();
        read_clk();
        expect_val("R6", S_DATA, 0);
        flush_checks();

        // R7: release on direction low, no stale data afterwards
        ser_rw = 1'b0;
        ticks(5);
        expect_val("R7", S_OE, 0);
        flush_checks();
        ser_rw = 1'b1;
        ticks(5);
        expect_val("R7", S_OE, 1);
        expect_val("R7", S_DATA, 0);
        flush_checks();
        read_clk();
        expect_val("R7", S_DATA, 0);
        flush_checks();

        // R2: reads never disturb the live word
        expect_fields("R2", shadow_exp);
        flush_checks();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule